// File: doc/BRIEF.md
# Frequency-Word Register Bank with Two-Wire Target Interface

This block is a target on a two-wire serial bus (I2C, standard mode). It holds four 48-bit frequency words and a one-byte selector. It drives the chosen word and its 2-bit index straight to the synthesizer logic next to it. The bus lines are brought into the system clock domain and edge-detected there, and the block only ever answers. It never starts a transfer. It pulls SDA low for exactly two reasons: to acknowledge a byte, or to send a zero bit of read data.

A transfer starts with START and the 7-bit device address plus the R/W bit. In a write, the next byte loads an 8-bit address pointer, and every byte after that is stored at the pointer, which then steps by one. A read returns bytes from the pointer, also stepping by one. The four words sit in the map in a scrambled order. A separate selector byte names the active word. Writes aimed at the active word are acknowledged but dropped, so the output can only change when the selector changes.

Top module: `freq_word_bank`

## Requirements
- R1: After reset the selector is 00, all four words are zero, `active_sel` is 0, `active_word` is 0 and `sda_oe` is low.
- R2: The block answers only to device address 69h. It acknowledges that address by driving `sda_oe` during the 9th SCL clock. Any other address gets no acknowledge, and the block keeps SDA released until the next START.
- R3: In a write, the byte after the address byte sets the pointer. Each following data byte is stored at the pointer, acknowledged on its 9th clock, and the pointer then increments by one, also across word boundaries.
- R4: Word 2 occupies 10h–15h, word 1 occupies 16h–1Bh, word 0 occupies 1Ch–21h and word 3 occupies 22h–27h. Within a word, byte k after the lowest address holds bits 47−8k down to 40−8k.
- R5: The selector sits at 40h. Bits 1:0 pick the word shown on `active_word` and `active_sel`. Bits 7:2 are not stored and read back as zero.
- R6: A write to any byte of the word currently selected is acknowledged, but it changes neither that word nor `active_word`.
- R7: Writes to addresses outside the 25 mapped bytes are acknowledged and discarded. Reads there return 00h.
- R8: When the R/W bit is 1, the block sends the byte at the pointer MSB first. It changes SDA only while SCL is low, releases SDA on the 9th clock, and increments the pointer after each byte. The pointer is kept across a repeated START.
- R9: A master NACK after a read byte ends the read. The block keeps SDA released through any further clocks, and it accepts a repeated START that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| active_word | output | 48 | Currently selected frequency word |
| active_sel | output | 2 | Index of the selected word |

## Verification
Two functions can meet in one clock. The strobe that stores a received data byte is one. The protection test that compares that byte's target word against the selector is the other. It is also possible for a selector write to change which word is protected between two bytes of one block write. The bench provokes this in two ways. It writes every word under each of the four selector values. It also runs a block write that starts in one word and runs into the selected one. It judges the result from a bench-side model of the map, by reading back all 24 word bytes and watching `active_word` around each transfer.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int NUM_WORDS  = 4;
  localparam int WORD_BYTES = 6;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int SEL_W      = $clog2(NUM_WORDS);
  localparam int IDX_W      = $clog2(WORD_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVA, ST_ACKA, ST_MADR, ST_ACKM,
    ST_WDAT, ST_ACKW, ST_RDAT, ST_RACK, ST_HOLD
  } bus_st_e;

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] word;
    logic [IDX_W-1:0] idx;
  } map_t;
endpackage

// File: rtl/fw_line_sync.sv
module fw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level = pipe_q[STAGES-1];
  assign rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/fw_regbank.sv
module fw_regbank
  import fw_pkg::*;
#(
  parameter logic [7:0] MAP_BASE = 8'h10,
  parameter logic [7:0] SEL_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [WORD_W-1:0] active_word,
  output logic [SEL_W-1:0]  active_sel
);
  localparam int MAP_SPAN = NUM_WORDS * WORD_BYTES;

  // Slots in address order hold words 2,1,0,3.
  function automatic map_t decode(input logic [7:0] a);
    map_t       m;
    logic [7:0] off;
    logic [7:0] slot;
    off    = a - MAP_BASE;
    slot   = off / 8'(WORD_BYTES);
    m.hit  = (off < 8'(MAP_SPAN));
    m.word = (slot[SEL_W-1:0] == SEL_W'(NUM_WORDS - 1)) ? slot[SEL_W-1:0]
           : SEL_W'(NUM_WORDS - 2) - slot[SEL_W-1:0];
    m.idx  = IDX_W'(off - slot * 8'(WORD_BYTES));
    return m;
  endfunction

  map_t             wm, rm;
  logic [SEL_W-1:0] sel_q;
  logic             sel_we;
  logic [WORD_W-1:0] words [NUM_WORDS];

  assign wm     = decode(wr_addr);
  assign rm     = decode(rd_addr);
  assign sel_we = wr_en && (wr_addr == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= wr_data[SEL_W-1:0];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              we;
    logic [WORD_W-1:0] q, d;
    assign we = wr_en && wm.hit && (wm.word == SEL_W'(w)) && (wm.word != sel_q);
    always_comb begin
      d = q;
      for (int b = 0; b < WORD_BYTES; b++)
        if (wm.idx == IDX_W'(WORD_BYTES - 1 - b)) d[b*8 +: 8] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end
    assign words[w] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rm.hit) begin
      for (int b = 0; b < WORD_BYTES; b++)
        if (rm.idx == IDX_W'(WORD_BYTES - 1 - b)) rd_data = words[rm.word][b*8 +: 8];
    end else if (rd_addr == SEL_ADDR) begin
      rd_data = {{(8-SEL_W){1'b0}}, sel_q};
    end
  end

  assign active_word = words[sel_q];
  assign active_sel  = sel_q;

  p_sel_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> active_sel == $past(wr_data[SEL_W-1:0]));
  p_active_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wm.hit && wm.word == sel_q) |=> $stable(active_word));
  p_unmapped_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wm.hit && !sel_we) |=> ($stable(active_word) && $stable(active_sel)));
endmodule

// File: rtl/fw_target_ctrl.sv
module fw_target_ctrl
  import fw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  bus_st_e    st_q, st_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, ptr_q, ptr_d, wa_q, wa_d, wd_q, wd_d;
  logic       rw_q, rw_d, nack_q, nack_d, oe_q, oe_d, we_q, we_d;
  logic       start_c, stop_c;

  assign start_c = sda_fall & scl;
  assign stop_c  = sda_rise & scl;

  always_comb begin
    st_d = st_q; bit_d = bit_q; sh_d = sh_q; ptr_d = ptr_q;
    wa_d = wa_q; wd_d = wd_q; rw_d = rw_q; nack_d = nack_q;
    oe_d = oe_q; we_d = 1'b0;
    if (stop_c) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_c) begin
      st_d = ST_DEVA; bit_d = '0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_DEVA, ST_MADR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            oe_d = 1'b1;
            if (st_q == ST_DEVA) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_d = sh_q[0]; st_d = ST_ACKA;
              end else begin
                oe_d = 1'b0; st_d = ST_HOLD;
              end
            end else if (st_q == ST_MADR) begin
              ptr_d = sh_q; st_d = ST_ACKM;
            end else begin
              we_d = 1'b1; wa_d = ptr_q; wd_d = sh_q;
              ptr_d = ptr_q + 8'd1; st_d = ST_ACKW;
            end
          end
        end
        ST_ACKA: if (scl_fall) begin
          bit_d = '0;
          if (rw_q) begin
            st_d = ST_RDAT; sh_d = rd_data; oe_d = ~rd_data[7];
          end else begin
            st_d = ST_MADR; oe_d = 1'b0;
          end
        end
        ST_ACKM, ST_ACKW: if (scl_fall) begin
          st_d = ST_WDAT; bit_d = '0; oe_d = 1'b0;
        end
        ST_RDAT: begin
          if (scl_rise) bit_d = bit_q + 4'd1;
          else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0; ptr_d = ptr_q + 8'd1; st_d = ST_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_d = sda;
          else if (scl_fall) begin
            if (nack_q) st_d = ST_HOLD;
            else begin
              st_d = ST_RDAT; sh_d = rd_data; oe_d = ~rd_data[7]; bit_d = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; ptr_q <= '0;
      wa_q <= '0; wd_q <= '0; rw_q <= 1'b0; nack_q <= 1'b0;
      oe_q <= 1'b0; we_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d; ptr_q <= ptr_d;
      wa_q <= wa_d; wd_q <= wd_d; rw_q <= rw_d; nack_q <= nack_d;
      oe_q <= oe_d; we_q <= we_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sda_oe  = oe_q;

  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl);
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD || st_q == ST_IDLE) |-> !oe_q);
  p_store_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (oe_q && st_q == ST_ACKW));
endmodule

// File: rtl/freq_word_bank.sv
module freq_word_bank
  import fw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] MAP_BASE    = 8'h10,
  parameter logic [7:0] SEL_ADDR    = 8'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [WORD_W-1:0] active_word,
  output logic [SEL_W-1:0]  active_sel
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, lvl, rse, fal;
  logic [7:0]       ptr, rd_data, wr_addr, wr_data;
  logic             wr_en;

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < LINES; i++) begin : g_sync
    fw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(raw[i]),
      .level(lvl[i]), .rise(rse[i]), .fall(fal[i]));
  end

  fw_target_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scl(lvl[0]), .scl_rise(rse[0]), .scl_fall(fal[0]),
    .sda(lvl[1]), .sda_rise(rse[1]), .sda_fall(fal[1]),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe));

  fw_regbank #(.MAP_BASE(MAP_BASE), .SEL_ADDR(SEL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .active_word(active_word), .active_sel(active_sel));
endmodule

// File: tb/sim_freq_word_bank.sv
module sim_freq_word_bank;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] active_word;
  logic [1:0]  active_sel;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  freq_word_bank u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .active_word(active_word), .active_sel(active_sel));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [47:0] m_word [4];
  logic [1:0]  m_sel;
  logic [7:0]  buf_d [32];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int base_of(input int w);
    case (w)
      0: return 'h1C;
      1: return 'h16;
      2: return 'h10;
      default: return 'h22;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input int a);
    for (int w = 0; w < 4; w++)
      if (a >= base_of(w) && a < base_of(w) + 6) return m_word[w][47 - 8*(a - base_of(w)) -: 8];
    if (a == 'h40) return {6'b0, m_sel};
    return 8'h00;
  endfunction

  task automatic model_wr(input int a, input logic [7:0] d);
    for (int w = 0; w < 4; w++)
      if (a >= base_of(w) && a < base_of(w) + 6 && w != int'(m_sel))
        m_word[w][47 - 8*(a - base_of(w)) -: 8] = d;
    if (a == 'h40) m_sel = d[1:0];
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input int a, input int n, input string req);
    bit ack;
    bstart();
    wbyte({DEV, 1'b0}, ack); check(ack, "R2 addr ack", 64'(ack), 1);
    wbyte(8'(a), ack);       check(ack, "R3 ptr ack", 64'(ack), 1);
    for (int i = 0; i < n; i++) begin
      wbyte(buf_d[i], ack);
      check(ack, req, 64'(ack), 1);
      model_wr((a + i) & 'hFF, buf_d[i]);
    end
    bstop();
  endtask

  task automatic read_seq(input int a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bstart();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'(a), ack);
    bstart();
    wbyte({DEV, 1'b1}, ack); check(ack, "R8 read addr ack", 64'(ack), 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      check(b == model_rd(a + i), req, 64'(b), 64'(model_rd(a + i)));
    end
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int w = 0; w < 4; w++) m_word[w] = '0;
    m_sel = '0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    check(active_sel == 2'd0, "R1 sel", 64'(active_sel), 0);
    check(active_word == 48'd0, "R1 word", active_word, 0);
    check(!sda_oe, "R1 sda released", 64'(sda_oe), 0);
    read_seq('h10, 24, "R1 words zero");

    // R2 foreign address: no ack, data ignored
    bstart();
    wbyte({7'h6A, 1'b0}, ack); check(!ack, "R2 foreign nack", 64'(ack), 0);
    wbyte(8'h40, ack);         check(!ack, "R2 ignored byte", 64'(ack), 0);
    wbyte(8'h03, ack);         check(!ack, "R2 ignored byte", 64'(ack), 0);
    bstop();
    check(active_sel == 2'd0, "R2 sel untouched", 64'(active_sel), 0);

    // R4 R5 R6 sweep over every selector value
    for (int s = 0; s < 4; s++) begin
      buf_d[0] = 8'(s);
      write_seq('h40, 1, "R5 sel ack");
      check(active_sel == 2'(s), "R5 active_sel", 64'(active_sel), 64'(s));
      check(active_word == m_word[s], "R5 active_word", active_word, m_word[s]);
      for (int w = 0; w < 4; w++) begin
        for (int k = 0; k < 6; k++) buf_d[k] = 8'(s*64 + w*16 + k*3 + 1);
        write_seq(base_of(w), 6, "R6 write ack");
      end
      check(active_word == m_word[s], "R6 active frozen", active_word, m_word[s]);
      read_seq('h10, 24, "R4 map readback");
      read_seq('h40, 1, "R5 sel readback");
    end

    // R7 unmapped writes and reads
    buf_d[0] = 8'hA5; buf_d[1] = 8'h5A;
    write_seq('h08, 2, "R7 unmapped ack");
    write_seq('h30, 1, "R7 unmapped ack");
    read_seq('h08, 2, "R7 unmapped read");
    read_seq('h28, 2, "R7 unmapped read");
    check(active_word == m_word[m_sel], "R7 no effect", active_word, m_word[m_sel]);

    // R5 reserved bits
    buf_d[0] = 8'hFE;
    write_seq('h40, 1, "R5 sel ack");
    check(active_sel == 2'd2, "R5 low bits", 64'(active_sel), 2);
    read_seq('h40, 1, "R5 reserved zero");

    // R3 R6 block write crossing from word 1 into selected word 0
    buf_d[0] = 8'h00;
    write_seq('h40, 1, "R5 sel ack");
    for (int k = 0; k < 4; k++) buf_d[k] = 8'hC0 + 8'(k);
    write_seq('h1A, 4, "R3 cross ack");
    read_seq('h16, 12, "R3 cross readback");
    check(active_word == m_word[0], "R6 cross frozen", active_word, m_word[0]);

    // R9 master NACK, released clocks, repeated START
    bstart();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h22, ack);
    bstart();
    wbyte({DEV, 1'b1}, ack);
    rbyte(1'b0, b); check(b == model_rd('h22), "R8 first read", 64'(b), 64'(model_rd('h22)));
    rbyte(1'b0, b); check(b == 8'hFF, "R9 released after nack", 64'(b), 64'hFF);
    bstart();
    wbyte({DEV, 1'b1}, ack); check(ack, "R9 restart ack", 64'(ack), 1);
    rbyte(1'b0, b); check(b == model_rd('h23), "R8 pointer kept", 64'(b), 64'(model_rd('h23)));
    bstop();
    check(!sda_oe, "R9 idle released", 64'(sda_oe), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule